// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block gathers eight interrupt request lines into one interrupt output for a processor. Each line is edge-triggered: a rising level latches a pending request. A request that is pending and not masked is compared against the requests already being serviced. Priority is measured from a rotation base that can be moved, so the highest-priority line changes when the base moves. When a pending request outranks everything in service, the block raises its interrupt output. On an acknowledge strobe it returns an 8-bit vector in the same cycle. That vector is a programmed base with the line number in its low three bits.

Software drives the block through a byte-wide port with two addresses. A write to address 0 with bit 4 set starts an initialization sequence, which continues on address 1. Other writes to address 0 carry commands. These cover end-of-service handling, priority rotation, read-back selection, the special mask mode and polling. Outside initialization, address 1 reaches the mask register. A poll read lets software fetch and retire the winning request without using the acknowledge strobe.

Top module: `rot_pic_core`

## Requirements
- R1: A request bit is set only when its input line rises, compared with the level seen on the previous clock. A line held high sets its bit once. It can set the bit again only after it has gone low and then high.
- R2: Priority rank is (line − base) mod 8, and the smallest rank wins. After initialization the base is 0, so line 0 is the highest.
- R3: `int_req` is high only when the best unmasked pending request has a strictly better rank than the best in-service line. A request with the same rank as the in-service line does not raise it.
- R4: While `inta` is high, `int_vector` is {vector base[7:3], line}. At that clock edge the line's pending bit is cleared and, when auto-EOI is off, its in-service bit is set.
- R5: With auto-EOI on, an acknowledge leaves the in-service register unchanged. Command word 0x80 (bits 7:5 = 100) turns on rotate-in-auto-EOI, and 0x00 turns it off. While it is on, each acknowledge moves the base to line+1.
- R6: A write to address 0 with bit 4 set clears all state (pending, mask, in-service, base, modes) and also clears the previous-level register of every line. Bit 0 of that word asks for a mode word. The next three writes to address 1 are, in order: the vector base (bits 7:3), an ignored cascade word, and the mode word only if it was asked for. In the mode word, bit 4 turns on nested-cascade mode and bit 1 turns on auto-EOI.
- R7: Outside initialization, a write to address 1 loads the mask register and a read from address 1 returns it. A masked line that has a pending bit does not raise `int_req`.
- R8: A write to address 0 with bits 4:3 = 01 is a mode command. When its bit 1 is set, its bit 0 selects what address 0 reads back: 1 selects the in-service register and 0 selects the pending register.
- R9: Command 0x20 (bits 7:5 = 001) clears the highest-ranked in-service bit. Command 0xA0 (bits 7:5 = 101) does the same and also moves the base to that line+1.
- R10: Command 0x60|n (bits 7:5 = 011) clears in-service bit n. Command 0xE0|n (bits 7:5 = 111) clears it and sets the base to n+1. Command 0xC0|n (bits 7:5 = 110) sets the base to n+1.
- R11: A mode command with bit 2 set arms a poll. The next read at either address returns 0x80|line and clears both the pending and in-service bits of that line. If nothing would raise `int_req`, the read returns 0x00.
- R12: A mode command with bit 6 set loads the special-mask flag from bit 5. While the flag is set, in-service lines that are masked do not block lower-ranked requests.
- R13: In nested-cascade mode, the in-service bit of the cascade line (line 2) is left out of the blocking comparison. A new request on that line can then interrupt its own service.
- R14: An acknowledge with no winning request returns vector base|7 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has effect only for a poll) |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| int_req | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge strobe |
| int_vector | output | 8 | Vector, valid while `inta` is high |

## Verification
The bench targets the strict-rank comparison. A request of the same rank as the line being serviced must stay silent, and a design that compared with "less or equal" would let a line interrupt itself. Rotation is checked after a set-priority command, a rotating non-specific EOI, a rotating specific EOI and rotate-in-auto-EOI; a design that wrapped the base wrongly would vector the wrong line. Three more cases need exact behaviour. A line held high across initialization must be seen again as a new edge. A poll read must retire the line in both registers. An acknowledge with nothing pending must return base|7 and leave every register unchanged.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NIRQ = 8;
    localparam int IW   = $clog2(NIRQ);
    localparam int DW   = 8;

    typedef struct packed {
        logic          hit;
        logic [IW-1:0] rank;
        logic [IW-1:0] line;
    } prio_t;

    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_VEC,
        INIT_CASC,
        INIT_MODE
    } init_e;

    typedef enum logic [2:0] {
        CMD_RAEOI_OFF = 3'b000,
        CMD_NS_EOI    = 3'b001,
        CMD_NOP       = 3'b010,
        CMD_SP_EOI    = 3'b011,
        CMD_RAEOI_ON  = 3'b100,
        CMD_ROT_NS    = 3'b101,
        CMD_SET_BASE  = 3'b110,
        CMD_ROT_SP    = 3'b111
    } cmd_e;

    // Lowest rank measured from the rotation base wins.
    function automatic prio_t find_best(logic [NIRQ-1:0] m, logic [IW-1:0] base);
        prio_t r;
        logic [IW-1:0] idx;
        r = '0;
        for (int p = NIRQ - 1; p >= 0; p--) begin
            idx = base + IW'(p);
            if (m[idx]) begin
                r.hit  = 1'b1;
                r.rank = IW'(p);
                r.line = idx;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_edge_detect.sv
module pic_edge_detect
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [NIRQ-1:0] lines,
    output logic [NIRQ-1:0] rise
);
    logic [NIRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst || clr) prev_q <= '0;
        else            prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/pic_prio_find.sv
module pic_prio_find
    import pic_pkg::*;
(
    input  logic [NIRQ-1:0] mask,
    input  logic [IW-1:0]   base,
    output prio_t           best
);
    always_comb best = find_best(mask, base);
endmodule

// File: rtl/rot_pic_core.sv
module rot_pic_core
    import pic_pkg::*;
#(
    parameter int CASC_LINE = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    irq_in,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          int_req,
    input  logic          inta,
    output logic [7:0]    int_vector
);
    localparam int NSRCH = 3;   // pending, blocking in-service, raw in-service
    localparam int VBW   = DW - IW;

    logic [NIRQ-1:0] irr, imr, isr, irr_n, imr_n, isr_n;
    logic [IW-1:0]   base, base_n;
    logic [VBW-1:0]  vbase, vbase_n;
    logic            read_isr, read_isr_n, poll_arm, poll_arm_n;
    logic            smm, smm_n, sfnm, sfnm_n, aeoi, aeoi_n;
    logic            rot_aeoi, rot_aeoi_n, need_mode, need_mode_n;
    init_e           init_st, init_st_n;

    logic [NIRQ-1:0] rise;
    logic            init_start;
    logic [NIRQ-1:0] srch_mask [NSRCH];
    prio_t           srch_best [NSRCH];
    logic [NIRQ-1:0] casc_bit;

    assign init_start = bus_wr && !bus_addr && bus_wdata[4];
    assign casc_bit   = NIRQ'(1) << CASC_LINE;

    pic_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .clr   (init_start),
        .lines (irq_in),
        .rise  (rise)
    );

    assign srch_mask[0] = irr & ~imr;
    assign srch_mask[1] = isr & ~(smm ? imr : '0) & ~(sfnm ? casc_bit : '0);
    assign srch_mask[2] = isr;

    for (genvar g = 0; g < NSRCH; g++) begin : g_srch
        pic_prio_find u_find (
            .mask (srch_mask[g]),
            .base (base),
            .best (srch_best[g])
        );
    end

    assign int_req = srch_best[0].hit &&
                     (!srch_best[1].hit || (srch_best[0].rank < srch_best[1].rank));

    assign int_vector = {vbase, int_req ? srch_best[0].line : IW'(NIRQ - 1)};

    always_comb begin
        if (poll_arm)
            bus_rdata = int_req ? {1'b1, {(DW-1-IW){1'b0}}, srch_best[0].line} : '0;
        else if (bus_addr)
            bus_rdata = imr;
        else
            bus_rdata = read_isr ? isr : irr;
    end

    always_comb begin
        cmd_e cmd;
        irr_n       = irr | rise;
        imr_n       = imr;
        isr_n       = isr;
        base_n      = base;
        vbase_n     = vbase;
        read_isr_n  = read_isr;
        poll_arm_n  = poll_arm;
        smm_n       = smm;
        sfnm_n      = sfnm;
        aeoi_n      = aeoi;
        rot_aeoi_n  = rot_aeoi;
        need_mode_n = need_mode;
        init_st_n   = init_st;
        cmd         = cmd_e'(bus_wdata[7:5]);

        if (inta && int_req) begin
            irr_n[srch_best[0].line] = 1'b0;
            if (!aeoi)
                isr_n[srch_best[0].line] = 1'b1;
            else if (rot_aeoi)
                base_n = srch_best[0].line + IW'(1);
        end

        if (bus_rd && poll_arm) begin
            poll_arm_n = 1'b0;
            if (int_req) begin
                irr_n[srch_best[0].line] = 1'b0;
                isr_n[srch_best[0].line] = 1'b0;
            end
        end

        if (bus_wr && !bus_addr && !bus_wdata[4]) begin
            if (bus_wdata[3]) begin
                if (bus_wdata[1]) read_isr_n = bus_wdata[0];
                if (bus_wdata[2]) poll_arm_n = 1'b1;
                if (bus_wdata[6]) smm_n      = bus_wdata[5];
            end else begin
                unique case (cmd)
                    CMD_RAEOI_OFF: rot_aeoi_n = 1'b0;
                    CMD_RAEOI_ON:  rot_aeoi_n = 1'b1;
                    CMD_NS_EOI, CMD_ROT_NS: begin
                        if (srch_best[2].hit) begin
                            isr_n[srch_best[2].line] = 1'b0;
                            if (cmd == CMD_ROT_NS)
                                base_n = srch_best[2].line + IW'(1);
                        end
                    end
                    CMD_SP_EOI: isr_n[bus_wdata[IW-1:0]] = 1'b0;
                    CMD_ROT_SP: begin
                        isr_n[bus_wdata[IW-1:0]] = 1'b0;
                        base_n = bus_wdata[IW-1:0] + IW'(1);
                    end
                    CMD_SET_BASE: base_n = bus_wdata[IW-1:0] + IW'(1);
                    default: ;
                endcase
            end
        end

        if (bus_wr && bus_addr) begin
            unique case (init_st)
                INIT_IDLE: imr_n = bus_wdata;
                INIT_VEC: begin
                    vbase_n   = bus_wdata[DW-1:IW];
                    init_st_n = INIT_CASC;
                end
                INIT_CASC: init_st_n = need_mode ? INIT_MODE : INIT_IDLE;
                INIT_MODE: begin
                    sfnm_n    = bus_wdata[4];
                    aeoi_n    = bus_wdata[1];
                    init_st_n = INIT_IDLE;
                end
                default: init_st_n = INIT_IDLE;
            endcase
        end

        if (init_start) begin
            irr_n       = '0;
            imr_n       = '0;
            isr_n       = '0;
            base_n      = '0;
            vbase_n     = '0;
            read_isr_n  = 1'b0;
            poll_arm_n  = 1'b0;
            smm_n       = 1'b0;
            sfnm_n      = 1'b0;
            aeoi_n      = 1'b0;
            rot_aeoi_n  = 1'b0;
            need_mode_n = bus_wdata[0];
            init_st_n   = INIT_VEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr       <= '0;
            imr       <= '0;
            isr       <= '0;
            base      <= '0;
            vbase     <= '0;
            read_isr  <= 1'b0;
            poll_arm  <= 1'b0;
            smm       <= 1'b0;
            sfnm      <= 1'b0;
            aeoi      <= 1'b0;
            rot_aeoi  <= 1'b0;
            need_mode <= 1'b0;
            init_st   <= INIT_IDLE;
        end else begin
            irr       <= irr_n;
            imr       <= imr_n;
            isr       <= isr_n;
            base      <= base_n;
            vbase     <= vbase_n;
            read_isr  <= read_isr_n;
            poll_arm  <= poll_arm_n;
            smm       <= smm_n;
            sfnm      <= sfnm_n;
            aeoi      <= aeoi_n;
            rot_aeoi  <= rot_aeoi_n;
            need_mode <= need_mode_n;
            init_st   <= init_st_n;
        end
    end
endmodule

// File: rtl/rot_pic_checker.sv
module rot_pic_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] irq_in,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       int_req,
    input logic       inta,
    input logic [7:0] int_vector,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] imr,
    input logic       aeoi
);
    AST_IRR_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~$past(irr)) & ~$past(irq_in)) == 8'h00); // R1

    AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((irr & ~imr) != 8'h00)); // R3

    AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (rst)
        (inta && int_req && !aeoi && !bus_wr && !bus_rd) |=> isr[$past(int_vector[2:0])]); // R4

    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (inta && aeoi && !bus_wr && !bus_rd) |=> $stable(isr)); // R5

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (isr == 8'h00 && imr == 8'h00)); // R6

    AST_SPURIOUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_req && !bus_wr && !bus_rd) |=> $stable(isr)); // R14
endmodule

bind rot_pic_core rot_pic_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .int_req    (int_req),
    .inta       (inta),
    .int_vector (int_vector),
    .irr        (irr),
    .isr        (isr),
    .imr        (imr),
    .aeoi       (aeoi)
);

// File: tb/rot_pic_core_tb.sv
`timescale 1ns/1ps
module rot_pic_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, int_vector;
    logic       int_req;
    int         n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    rot_pic_core dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_req(int_req), .inta(inta), .int_vector(int_vector)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v);
        inta = 1'b1;
        #1 v = int_vector;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic lines(logic [7:0] v);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic rd_irr(output logic [7:0] v);
        wr(1'b0, 8'h0A);
        rd(1'b0, v);
    endtask

    task automatic rd_isr(output logic [7:0] v);
        wr(1'b0, 8'h0B);
        rd(1'b0, v);
    endtask

    task automatic init(logic [7:0] vb, logic want_mode, logic [7:0] mode);
        wr(1'b0, want_mode ? 8'h11 : 8'h10);
        wr(1'b1, vb);
        wr(1'b1, 8'h00);
        if (want_mode) wr(1'b1, mode);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R3 reset int_req", {7'd0, int_req}, 8'h00);
        rd(1'b1, v); chk("R7 reset mask", v, 8'h00);
        rd(1'b0, v); chk("R8 reset pending", v, 8'h00);
    endtask

    task automatic t_edge;
        logic [7:0] v;
        init(8'h20, 1'b1, 8'h01);
        lines(8'h08);
        chk("R1 rise raises int", {7'd0, int_req}, 8'h01);
        ack(v); chk("R4 vector line3", v, 8'h23);
        repeat (3) @(negedge clk);
        rd_irr(v); chk("R1 held high no re-set", v, 8'h00);
        rd_isr(v); chk("R4 in-service set", v, 8'h08);
        lines(8'h00); lines(8'h08);
        rd_irr(v); chk("R1 re-arm after low", v, 8'h08);
        chk("R3 equal rank stays low", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'h20);
        chk("R3 raised after EOI", {7'd0, int_req}, 8'h01);
        ack(v); wr(1'b0, 8'h20); lines(8'h00);
    endtask

    task automatic t_nest;
        logic [7:0] v;
        lines(8'h24);
        ack(v); chk("R2 line2 beats line5", v, 8'h22);
        chk("R3 lower rank blocked", {7'd0, int_req}, 8'h00);
        lines(8'h26);
        chk("R3 higher rank nests", {7'd0, int_req}, 8'h01);
        ack(v); chk("R4 vector line1", v, 8'h21);
        rd_isr(v); chk("R4 two in service", v, 8'h06);
        wr(1'b0, 8'h20);
        rd_isr(v); chk("R9 EOI clears top", v, 8'h04);
        wr(1'b0, 8'h20);
        ack(v); chk("R9 pending line5 next", v, 8'h25);
        wr(1'b0, 8'h20); lines(8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr(1'b1, 8'h10);
        rd(1'b1, v); chk("R7 mask readback", v, 8'h10);
        lines(8'h10);
        chk("R7 masked no int", {7'd0, int_req}, 8'h00);
        rd_irr(v); chk("R7 masked still pending", v, 8'h10);
        wr(1'b1, 8'h00);
        ack(v); chk("R7 unmasked vector", v, 8'h24);
        wr(1'b0, 8'h20); lines(8'h00);
    endtask

    task automatic t_rotate;
        logic [7:0] v;
        wr(1'b0, 8'hC4);
        lines(8'h50);
        ack(v); chk("R10 base5 picks line6", v, 8'h26);
        chk("R3 line4 below line6", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'hE6);
        rd_isr(v); chk("R10 rotating specific EOI", v, 8'h00);
        ack(v); chk("R10 line4 after rotation", v, 8'h24);
        wr(1'b0, 8'h64);
        rd_isr(v); chk("R10 specific EOI", v, 8'h00);
        wr(1'b0, 8'hC7); lines(8'h00);
    endtask

    task automatic t_rot_ns;
        logic [7:0] v;
        lines(8'h08);
        ack(v);
        wr(1'b0, 8'hA0);
        lines(8'h2C);
        ack(v); chk("R9 rotate base4 picks line5", v, 8'h25);
        chk("R9 line2 ranked below", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'h20);
        ack(v); chk("R9 line2 after EOI", v, 8'h22);
        wr(1'b0, 8'h20); lines(8'h00); wr(1'b0, 8'hC7);
    endtask

    task automatic t_aeoi;
        logic [7:0] v;
        init(8'h20, 1'b1, 8'h03);
        lines(8'h02);
        ack(v); chk("R5 auto-EOI vector", v, 8'h21);
        rd_isr(v); chk("R5 auto-EOI no in-service", v, 8'h00);
        wr(1'b0, 8'h80);
        lines(8'h12);
        ack(v); chk("R5 vector line4", v, 8'h24);
        lines(8'h5A);
        ack(v); chk("R5 base moved to 5", v, 8'h26);
        wr(1'b0, 8'h00);
        ack(v); chk("R5 remaining line3", v, 8'h23);
        rd_isr(v); chk("R5 in-service empty", v, 8'h00);
        lines(8'h00);
    endtask

    task automatic t_poll;
        logic [7:0] v;
        init(8'h20, 1'b1, 8'h01);
        lines(8'h40);
        wr(1'b0, 8'h0C);
        rd(1'b0, v); chk("R11 poll value", v, 8'h86);
        chk("R11 int cleared", {7'd0, int_req}, 8'h00);
        rd_irr(v); chk("R11 pending cleared", v, 8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b1, v); chk("R11 empty poll", v, 8'h00);
        lines(8'h00);
    endtask

    task automatic t_smm;
        logic [7:0] v;
        lines(8'h04);
        ack(v);
        lines(8'h24);
        chk("R12 blocked before mask mode", {7'd0, int_req}, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b0, 8'h68);
        chk("R12 special mask unblocks", {7'd0, int_req}, 8'h01);
        chk("R12 vector line5", int_vector, 8'h25);
        wr(1'b0, 8'h48);
        chk("R12 special mask off blocks", {7'd0, int_req}, 8'h00);
        lines(8'h00);
    endtask

    task automatic t_sfnm;
        logic [7:0] v;
        init(8'h20, 1'b1, 8'h11);
        lines(8'h04);
        ack(v);
        lines(8'h00); lines(8'h04);
        chk("R13 cascade line re-enters", {7'd0, int_req}, 8'h01);
        chk("R13 vector line2", int_vector, 8'h22);
        lines(8'h00);
    endtask

    task automatic t_spur;
        logic [7:0] v;
        init(8'h38, 1'b1, 8'h01);
        ack(v); chk("R14 spurious vector", v, 8'h3F);
        rd_isr(v); chk("R14 in-service unchanged", v, 8'h00);
        rd_irr(v); chk("R14 pending unchanged", v, 8'h00);
    endtask

    task automatic t_init;
        logic [7:0] v;
        wr(1'b1, 8'hFF);
        lines(8'h01);
        wr(1'b0, 8'h10);
        rd(1'b1, v); chk("R6 init clears mask", v, 8'h00);
        wr(1'b1, 8'h48);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h33);
        rd(1'b1, v); chk("R6 no mode word -> mask", v, 8'h33);
        rd_irr(v); chk("R6 held line re-detected", v, 8'h01);
        lines(8'h09);
        ack(v); chk("R6 new vector base", v, 8'h4B);
        lines(8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_edge;
        t_nest;
        t_mask;
        t_rotate;
        t_rot_ns;
        t_aeoi;
        t_poll;
        t_smm;
        t_sfnm;
        t_spur;
        t_init;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule